// File: doc/BRIEF.md
# Descriptor-Driven Configuration Copy Engine

This block is a bus master that sits beside a keyed configuration item store. It moves item bytes into system memory, so the host does not have to fetch them one access at a time. The host puts a 16-byte command record in memory and then rings a doorbell by writing the record's 64-bit physical address. The engine then works on its own until the record is done. It reads the record, may re-select an item key, copies or discards the requested number of bytes, and writes a completion word back over the first word of the record.

The item store keeps the current key and read offset. The engine asks for a new key with a one-cycle select pulse. The store reports how many bytes remain at the current offset and which byte is next. The engine consumes bytes with an advance pulse that carries a count. Memory is reached through a single-outstanding request/acknowledge port that has 32-bit word and single-byte accesses. Reading the doorbell window returns slices of a fixed identification constant, so software can find the engine.

Top module: `cfg_dma_engine`

## Requirements
- R1: A 4-byte doorbell write at offset 0 stores its low 32 bits as the upper half of a pending address. A following 4-byte write at offset 4 starts a command, with its record address equal to the pending value OR'd with the written low 32 bits.
- R2: An 8-byte doorbell write at offset 0 starts a command at the written 64-bit address. Every other doorbell write (other sizes, or other offsets) is ignored and starts nothing.
- R3: The pending address is cleared to zero when a command starts, so a later low-half-only write uses an upper half of zero.
- R4: The record is fetched as four word reads at base+0, +4, +8 and +12. Each word is big-endian, with the byte at the lower address in bits 31:24. The words are the control word, the byte length, the upper target address and the lower target address.
- R5: When control bit 3 is set, exactly one select pulse carrying control bits 31:16 as the key is issued before any byte moves.
- R6: Control bit 1 (copy) wins over bit 2 (skip). With neither bit set, no bytes move and nothing is consumed.
- R7: A copy writes the item's bytes, in offset order, to successive target addresses as byte writes. The item offset advances by one for each byte that is written.
- R8: When the selection is invalid or the item has no bytes left, a copy writes zero to every remaining target byte and consumes nothing.
- R9: A skip consumes the smaller of the length and the remaining item bytes with one advance, and makes no memory writes.
- R10: Completion is a word write to base+0 of value 0 on success and value 1 on failure. A failed record read moves no data and selects nothing. A failed byte write stops the copy at that byte without consuming it.
- R11: A doorbell read of size S bytes at offset O returns bytes O..O+S-1 of the constant 0x4346_4744_4D41_5F31, most significant byte first. An access that runs past byte 7 returns 0.
- R12: Busy rises on a start and falls after the completion write is acknowledged. Doorbell writes made while busy are ignored. No memory request or item pulse is made while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_we | input | 1 | Doorbell write strobe |
| db_off | input | 3 | Doorbell byte offset |
| db_sz | input | 4 | Doorbell access size in bytes |
| db_wdata | input | 64 | Doorbell write data |
| db_rdata | output | 64 | Identification slice for db_off/db_sz |
| busy | output | 1 | Command in progress |
| itm_sel | output | 1 | Select pulse to the item store |
| itm_key | output | 16 | Key to select |
| itm_avail | input | 32 | Bytes left at the current offset (0 if invalid) |
| itm_data | input | 8 | Item byte at the current offset |
| itm_adv | output | 1 | Consume pulse |
| itm_adv_cnt | output | 32 | Bytes consumed by the pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_word | output | 1 | Word access (else byte) |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 32 | Write data (byte in bits 7:0) |
| mem_ack | input | 1 | Request accepted/completed |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| mem_rdata | input | 32 | Read word, valid with mem_ack |

## Verification
The checker watches several properties on every cycle. Memory requests must be held steady until acknowledged. An idle engine must stay quiet. Select pulses must stay apart from data traffic. An advance must never exceed the bytes available. Busy may rise only after a doorbell write and may fall only after an acknowledged completion write. Other behaviours show only in the bench's scenarios, which compare every memory write against a scoreboard. These are the byte order of the record, copy order and zero-fill once an item is drained, skip lengths, which bit wins between copy and skip, clearing of the pending address, and the exact stopping point after a write failure.

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_5F31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        db_we,
  input  logic [2:0]  db_off,
  input  logic [3:0]  db_sz,
  input  logic [63:0] db_wdata,
  output logic [63:0] db_rdata,
  output logic        busy,
  output logic        itm_sel,
  output logic [15:0] itm_key,
  input  logic [31:0] itm_avail,
  input  logic [7:0]  itm_data,
  output logic        itm_adv,
  output logic [31:0] itm_adv_cnt,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_word,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SEL, S_MOVE, S_STAT} st_t;

  st_t         st;
  logic [63:0] pend, base, taddr;
  logic [31:0] ctrl, rem;
  logic [1:0]  idx;
  logic        fail;

  wire hi_wr = db_we && !busy && db_sz == 4'd4 && db_off == 3'd0;
  wire go_lo = db_we && !busy && db_sz == 4'd4 && db_off == 3'd4;
  wire go_wd = db_we && !busy && db_sz == 4'd8 && db_off == 3'd0;
  wire [63:0] go_addr = go_wd ? db_wdata : (pend | {32'h0, db_wdata[31:0]});

  wire mv_rd     = ctrl[1];
  wire mv_sk     = !ctrl[1] && ctrl[2];
  wire avail_nz  = itm_avail != 32'd0;
  wire moving_rd = st == S_MOVE && mv_rd && rem != 32'd0;
  wire [31:0] skip_n = (rem < itm_avail) ? rem : itm_avail;

  assign busy        = st != S_IDLE;
  assign itm_sel     = st == S_SEL;
  assign itm_key     = ctrl[31:16];
  assign itm_adv     = (st == S_MOVE && mv_sk && rem != 32'd0 && avail_nz) ||
                       (moving_rd && mem_ack && !mem_err && avail_nz);
  assign itm_adv_cnt = moving_rd ? 32'd1 : skip_n;
  assign mem_req     = st == S_FETCH || st == S_STAT || moving_rd;
  assign mem_we      = st == S_STAT || moving_rd;
  assign mem_word    = !moving_rd;
  assign mem_addr    = (st == S_MOVE) ? taddr :
                       (st == S_STAT) ? base : base + {60'h0, idx, 2'b00};
  assign mem_wdata   = (st == S_STAT) ? {31'h0, fail} :
                       {24'h0, avail_nz ? itm_data : 8'h00};

  always_comb begin
    int o, s;
    o = int'(db_off);
    s = int'(db_sz);
    db_rdata = 64'h0;
    if ((s == 1 || s == 2 || s == 4 || s == 8) && o + s <= 8) begin
      db_rdata = SIGNATURE >> ((8 - o - s) * 8);
      if (s != 8) db_rdata = db_rdata & ((64'd1 << (s * 8)) - 64'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pend  <= '0;
      base  <= '0;
      taddr <= '0;
      ctrl  <= '0;
      rem   <= '0;
      idx   <= '0;
      fail  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (hi_wr) pend <= {db_wdata[31:0], 32'h0};
          if (go_lo || go_wd) begin
            base <= go_addr;
            pend <= '0;
            idx  <= '0;
            fail <= 1'b0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            fail <= 1'b1;
            st   <= S_STAT;
          end else begin
            case (idx)
              2'd0: ctrl <= mem_rdata;
              2'd1: rem  <= mem_rdata;
              2'd2: taddr[63:32] <= mem_rdata;
              default: taddr[31:0] <= mem_rdata;
            endcase
            idx <= idx + 2'd1;
            if (idx == 2'd3) st <= ctrl[3] ? S_SEL : S_MOVE;
          end
        end
        S_SEL: st <= S_MOVE;
        S_MOVE: begin
          if ((!mv_rd && !mv_sk) || rem == 32'd0) st <= S_STAT;
          else if (mv_sk) rem <= 32'd0;
          else if (mem_ack) begin
            if (mem_err) begin
              fail <= 1'b1;
              st   <= S_STAT;
            end else begin
              rem   <= rem - 32'd1;
              taddr <= taddr + 64'd1;
            end
          end
        end
        S_STAT: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        db_we,
  input logic        itm_sel,
  input logic        itm_adv,
  input logic [31:0] itm_adv_cnt,
  input logic [31:0] itm_avail,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_word,
  input logic [63:0] mem_addr,
  input logic        mem_ack
);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !itm_sel && !itm_adv));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  adv_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    itm_adv |-> (itm_adv_cnt <= itm_avail && itm_adv_cnt != 32'd0));

  // R5
  sel_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    itm_sel |-> (!mem_req && !itm_adv));

  // R12
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(db_we));

  // R10
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_ack && mem_we && mem_word));
endmodule

bind cfg_dma_engine cfg_dma_engine_chk u_chk (.*);

// File: tb/cfg_dma_engine_tb.sv
module cfg_dma_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SIG = 64'h4346_4744_4D41_5F31;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        db_we = 1'b0;
  logic [2:0]  db_off = '0;
  logic [3:0]  db_sz = '0;
  logic [63:0] db_wdata = '0, db_rdata;
  logic        busy, itm_sel, itm_adv;
  logic [15:0] itm_key;
  logic [31:0] itm_avail, itm_adv_cnt;
  logic [7:0]  itm_data;
  logic        mem_req, mem_we, mem_word;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_dma_engine u_dut (.*);

  int n_checks = 0, n_fail = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // item store model
  function automatic int ilen(int key);
    return (key == 5) ? 10 : (key == 7) ? 3 : 0;
  endfunction
  function automatic logic [7:0] idat(int key, int off);
    return (key == 5) ? 8'(8'hA0 + off) : (key == 7) ? 8'(8'h70 + off) : 8'h00;
  endfunction

  int cur_key = 0, cur_off = 0, last_key = -1, sel_cnt = 0;
  always @(posedge clk) begin
    if (rst_n && itm_sel) begin
      cur_key  <= int'(itm_key);
      cur_off  <= 0;
      last_key <= int'(itm_key);
      sel_cnt  <= sel_cnt + 1;
    end else if (rst_n && itm_adv) cur_off <= cur_off + int'(itm_adv_cnt);
  end
  always_comb begin
    itm_avail = (ilen(cur_key) > cur_off) ? 32'(ilen(cur_key) - cur_off) : 32'd0;
    itm_data  = idat(cur_key, cur_off);
  end

  // memory model and scoreboard
  typedef struct { longint unsigned a; bit w; logic [31:0] d; string req; } wr_t;
  wr_t exp_q[$];
  logic [7:0] mem [longint unsigned];
  bit err_on = 0;
  longint unsigned err_addr = 0;

  function automatic logic [7:0] rdb(longint unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (rst_n && mem_req) begin
      longint unsigned a;
      a = mem_addr;
      mem_ack = 1'b1;
      mem_err = err_on && (a == err_addr);
      if (!mem_we) mem_rdata = {rdb(a), rdb(a+1), rdb(a+2), rdb(a+3)};
      else if (!mem_err) begin
        if (mem_word) begin
          mem[a] = mem_wdata[31:24]; mem[a+1] = mem_wdata[23:16];
          mem[a+2] = mem_wdata[15:8]; mem[a+3] = mem_wdata[7:0];
        end else mem[a] = mem_wdata[7:0];
        if (exp_q.size() == 0) chk(0, "R10", "unexpected write addr", longint'(a), 0);
        else begin
          wr_t e;
          e = exp_q.pop_front();
          chk(a == e.a, e.req, "write address", longint'(a), longint'(e.a));
          chk(mem_word == e.w, e.req, "write kind", longint'(mem_word), longint'(e.w));
          if (e.w) chk(mem_wdata == e.d, e.req, "word data", longint'(mem_wdata), longint'(e.d));
          else chk(mem_wdata[7:0] == e.d[7:0], e.req, "byte data", longint'(mem_wdata[7:0]), longint'(e.d[7:0]));
        end
      end
    end
  end

  task automatic expect_wr(longint unsigned a, bit w, logic [31:0] d, string req);
    wr_t e;
    e.a = a; e.w = w; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic put_desc(longint unsigned b, logic [31:0] c, logic [31:0] l, logic [63:0] t);
    logic [127:0] r;
    r = {c, l, t};
    for (int i = 0; i < 16; i++) mem[b + longint'(i)] = r[127 - 8*i -: 8];
  endtask

  task automatic db_write(logic [2:0] off, logic [3:0] sz, logic [63:0] d);
    @(negedge clk);
    db_we = 1'b1; db_off = off; db_sz = sz; db_wdata = d;
    @(negedge clk);
    db_we = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, req, "completion timeout", longint'(busy), 0);
    chk(exp_q.size() == 0, req, "writes missing", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic sig_rd(logic [2:0] off, logic [3:0] sz, logic [63:0] exp);
    @(negedge clk);
    db_off = off; db_sz = sz;
    #1 chk(db_rdata == exp, "R11", "signature slice", longint'(db_rdata), longint'(exp));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R12", "reset busy", longint'(busy), 0);
    chk(!mem_req, "R12", "reset mem_req", longint'(mem_req), 0);

    // R11 signature slices
    sig_rd(3'd0, 4'd8, SIG);
    sig_rd(3'd4, 4'd4, 64'h4D41_5F31);
    sig_rd(3'd0, 4'd1, 64'h43);
    sig_rd(3'd6, 4'd2, 64'h5F31);
    sig_rd(3'd5, 4'd4, 64'h0);

    // R1 R4 R5 R7: split doorbell, select key 5, copy 4
    put_desc(64'h1000, {16'd5, 16'h000A}, 32'd4, 64'h2000);
    for (int i = 0; i < 4; i++) expect_wr(64'h2000 + i, 0, 32'(8'hA0 + i), "R7");
    expect_wr(64'h1000, 1, 32'd0, "R10");
    db_write(3'd0, 4'd4, 64'h0);
    db_write(3'd4, 4'd4, 64'h1000);
    wait_idle("R1");
    chk(last_key == 5, "R5", "selected key", last_key, 5);

    // R2 R4 R8: 64-bit doorbell, no select, copy past end, target with upper half
    put_desc(64'h1100, 32'h0000_0002, 32'd8, 64'h1_0000_3000);
    for (int i = 0; i < 6; i++) expect_wr(64'h1_0000_3000 + i, 0, 32'(8'hA4 + i), "R4");
    expect_wr(64'h1_0000_3006, 0, 32'h0, "R8");
    expect_wr(64'h1_0000_3007, 0, 32'h0, "R8");
    expect_wr(64'h1100, 1, 32'd0, "R10");
    db_write(3'd0, 4'd8, 64'h1100);
    wait_idle("R2");

    // R9: select+skip 3, then copy 2
    put_desc(64'h1200, {16'd5, 16'h000C}, 32'd3, 64'h4000);
    expect_wr(64'h1200, 1, 32'd0, "R9");
    db_write(3'd0, 4'd8, 64'h1200);
    wait_idle("R9");
    put_desc(64'h1210, 32'h0000_0002, 32'd2, 64'h4100);
    expect_wr(64'h4100, 0, 32'hA3, "R9");
    expect_wr(64'h4101, 0, 32'hA4, "R9");
    expect_wr(64'h1210, 1, 32'd0, "R10");
    db_write(3'd0, 4'd8, 64'h1210);
    wait_idle("R9");

    // R9 R8: skip longer than item, then copy gives zero
    put_desc(64'h1220, {16'd7, 16'h000C}, 32'd10, 64'h4200);
    expect_wr(64'h1220, 1, 32'd0, "R9");
    db_write(3'd0, 4'd8, 64'h1220);
    wait_idle("R9");
    put_desc(64'h1230, 32'h0000_0002, 32'd1, 64'h4300);
    expect_wr(64'h4300, 0, 32'h0, "R8");
    expect_wr(64'h1230, 1, 32'd0, "R10");
    db_write(3'd0, 4'd8, 64'h1230);
    wait_idle("R8");

    // R6: neither bit -> nothing moves; then copy+skip -> copy
    put_desc(64'h1240, {16'd5, 16'h0008}, 32'd5, 64'h4400);
    expect_wr(64'h1240, 1, 32'd0, "R6");
    db_write(3'd0, 4'd8, 64'h1240);
    wait_idle("R6");
    put_desc(64'h1250, {16'd0, 16'h0006}, 32'd2, 64'h4500);
    expect_wr(64'h4500, 0, 32'hA0, "R6");
    expect_wr(64'h4501, 0, 32'hA1, "R6");
    expect_wr(64'h1250, 1, 32'd0, "R10");
    db_write(3'd0, 4'd8, 64'h1250);
    wait_idle("R6");

    // R8: invalid key copy -> zeros
    put_desc(64'h1260, {16'd99, 16'h000A}, 32'd2, 64'h4600);
    expect_wr(64'h4600, 0, 32'h0, "R8");
    expect_wr(64'h4601, 0, 32'h0, "R8");
    expect_wr(64'h1260, 1, 32'd0, "R10");
    db_write(3'd0, 4'd8, 64'h1260);
    wait_idle("R8");

    // R2: rejected doorbell writes
    db_write(3'd2, 4'd4, 64'h1260);
    db_write(3'd4, 4'd8, 64'h1260);
    db_write(3'd0, 4'd2, 64'h1260);
    db_write(3'd4, 4'd1, 64'h1260);
    @(negedge clk);
    chk(!busy, "R2", "rejected write started", longint'(busy), 0);

    // R3: high half set, start, then low-only write
    put_desc(64'h3_0000_0200, 32'h0, 32'h0, 64'h0);
    expect_wr(64'h3_0000_0200, 1, 32'd0, "R1");
    db_write(3'd0, 4'd4, 64'h3);
    db_write(3'd4, 4'd4, 64'h200);
    wait_idle("R1");
    put_desc(64'h1700, 32'h0, 32'h0, 64'h0);
    expect_wr(64'h1700, 1, 32'd0, "R3");
    db_write(3'd4, 4'd4, 64'h1700);
    wait_idle("R3");

    // R10: record fetch failure
    s0 = sel_cnt;
    put_desc(64'h1800, {16'd5, 16'h000A}, 32'd2, 64'h4800);
    err_on = 1; err_addr = 64'h1808;
    expect_wr(64'h1800, 1, 32'd1, "R10");
    db_write(3'd0, 4'd8, 64'h1800);
    wait_idle("R10");
    chk(sel_cnt == s0, "R10", "select after fetch error", sel_cnt, s0);

    // R10: write failure stops copy
    put_desc(64'h1900, {16'd5, 16'h000A}, 32'd4, 64'h2900);
    err_addr = 64'h2901;
    expect_wr(64'h2900, 0, 32'hA0, "R10");
    expect_wr(64'h1900, 1, 32'd1, "R10");
    db_write(3'd0, 4'd8, 64'h1900);
    wait_idle("R10");
    err_on = 0;
    put_desc(64'h1A00, 32'h0000_0002, 32'd1, 64'h2A00);
    expect_wr(64'h2A00, 0, 32'hA1, "R10");
    expect_wr(64'h1A00, 1, 32'd0, "R10");
    db_write(3'd0, 4'd8, 64'h1A00);
    wait_idle("R10");

    // R12: doorbell writes while busy are ignored
    put_desc(64'h1400, {16'd5, 16'h000A}, 32'd3, 64'h4A00);
    put_desc(64'h1500, 32'h0, 32'h0, 64'h0);
    for (int i = 0; i < 3; i++) expect_wr(64'h4A00 + i, 0, 32'(8'hA0 + i), "R12");
    expect_wr(64'h1400, 1, 32'd0, "R12");
    db_write(3'd0, 4'd8, 64'h1400);
    chk(busy, "R12", "busy after start", longint'(busy), 1);
    db_write(3'd0, 4'd8, 64'h1500);
    db_write(3'd0, 4'd4, 64'h5);
    wait_idle("R12");
    put_desc(64'h1600, 32'h0, 32'h0, 64'h0);
    expect_wr(64'h1600, 1, 32'd0, "R12");
    db_write(3'd4, 4'd4, 64'h1600);
    wait_idle("R12");
    repeat (4) @(negedge clk);
    chk(!busy, "R12", "idle at end", longint'(busy), 0);

    summary();
  end
endmodule